// File: doc/BRIEF.md
# SRAM Bank Supply and Retention Sequencer

This block decides the supply state of four independent on-chip SRAM banks. A global power-chain status from the sleep controller, a per-bank software power-off bit and a per-bank retention-enable bit together pick the supply state of each bank: full supply, a reduced retention supply that keeps the contents, or disconnection. A per-bank access flag, which gates the memory bus, is raised only once a bank's supply switch has settled after a return to full supply.

Software reaches the block through a small byte-wide configuration port. One register holds the four power-off bits. Each bank has its own control register, which holds the retention enable, a read-only ready bit, a sticky contents-lost flag and four reserved bits that keep a fixed pattern. A bus-side check turns any access to a bank that is not ready into a one-cycle error pulse with zero read data.

Each bank runs its own four-state sequencer. The states are DARK (disconnected), HOLD (retention supply), SETTLE (full supply, switch not yet settled) and LIVE (full supply, ready). The transitions are: DARK→HOLD and LIVE→HOLD or SETTLE→HOLD when retention is the target; any state→DARK when disconnection is the target; DARK→SETTLE and HOLD→SETTLE when full supply is the target; SETTLE→LIVE when the settle count expires. The target is disconnected if the power-off bit is set. Otherwise it is full if the chain is on, retention if the chain is off and retention is enabled, and disconnected if the chain is off and retention is disabled.

Top module: `sram_retention_ctrl`

## Requirements
- R1: After reset every bank has supply code 2'b10, every access flag is 1, retention enable is 1, the power-off bits are 0 and the lost flags are 0.
- R2: A bank whose power-off bit is 1 shows supply code 2'b00 from the cycle after the bit is seen, whatever the chain state.
- R3: With the chain on and the power-off bit 0, a bank moves to supply code 2'b10 whatever its retention enable holds.
- R4: With the chain off, the power-off bit 0 and retention enable 1, a bank shows supply code 2'b01.
- R5: With the chain off, the power-off bit 0 and retention enable 0, a bank shows supply code 2'b00.
- R6: On entry to supply 2'b10 from 2'b00 or 2'b01, the ready bit and the access flag rise exactly SETTLE_CYC cycles later (default 8). They fall in the same cycle that the supply code leaves 2'b10.
- R7: Bits [3:0] of each bank control register always read RSVD_INIT (default 4'b0110), and writes leave them unchanged.
- R8: A bus request to a bank whose ready bit is 0 gives bus_err = 1 and bus_rdata = 0 in the next cycle. A request to a ready bank gives bus_err = 0 and passes sram_rdata through with one cycle of latency. With no request, bus_err = 0 and bus_rdata = 0.
- R9: A bank that has been in supply 2'b00 sets its lost flag when it next enters 2'b10. Writing 1 to the flag clears it, and a set in the same cycle as a clear wins.
- R10: Register map. Address 0 holds the power-off bits in bits [3:0] (bank n in bit n) with bits [7:4] reading 0. Address 1+n is bank n's control register: bit 7 retention enable (read/write), bit 6 ready (read-only), bit 5 lost (write 1 to clear), bit 4 reads 0, bits [3:0] reserved. Other addresses read 0. Reads are combinational and writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_on | input | 1 | Power chain status from the sleep controller (1 = on) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| bus_req | input | 1 | Memory bus access request |
| bus_bank | input | 2 | Bank addressed by the bus request |
| sram_rdata | input | 32 | Read data from the SRAM array |
| bus_rdata | output | 32 | Gated read data returned to the bus |
| bus_err | output | 1 | One-cycle access error pulse |
| bank_supply | output | 8 | Supply code per bank, bank n in bits [2n+1:2n] |
| bank_access | output | 4 | Access-allowed flag per bank |

## Verification
Two functions can coincide in a single cycle. The first is a bus request landing on the very cycle in which a bank finishes settling. The bench provokes it by re-enabling a bank and then requesting it on every cycle, so that the last request before LIVE must fail and the first request in LIVE must pass. The second is a software write-one-to-clear of the lost flag on the same edge at which the bank re-enters full supply after disconnection. The bench drives the chain-on rise and the clearing write together, then expects the flag to read 1. A behavioural model judges both cases and the random traffic, and it is compared on every clock.

// File: rtl/srpc_pkg.sv
package srpc_pkg;
    typedef enum logic [1:0] {
        SUP_OFF  = 2'b00,
        SUP_RET  = 2'b01,
        SUP_FULL = 2'b10
    } supply_e;

    typedef enum logic [1:0] {
        BK_DARK,
        BK_HOLD,
        BK_SETTLE,
        BK_LIVE
    } bank_st_e;
endpackage

// File: rtl/srpc_bank_seq.sv
module srpc_bank_seq
    import srpc_pkg::*;
#(
    parameter int SETTLE_CYC = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    chain_on_i,
    input  logic    off_i,
    input  logic    ret_en_i,
    output supply_e supply_o,
    output logic    ready_o,
    output logic    lost_set_o
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(SETTLE_CYC - 1);

    bank_st_e      state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          gone_q;
    supply_e       target;
    logic          enter_settle;

    // target supply from the global chain and the bank's own bits
    always_comb begin
        if (off_i)           target = SUP_OFF;
        else if (chain_on_i) target = SUP_FULL;
        else if (ret_en_i)   target = SUP_RET;
        else                 target = SUP_OFF;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_LIVE: begin
                if (target == SUP_OFF)      state_d = BK_DARK;
                else if (target == SUP_RET) state_d = BK_HOLD;
            end
            BK_SETTLE: begin
                if (target == SUP_OFF)      state_d = BK_DARK;
                else if (target == SUP_RET) state_d = BK_HOLD;
                else if (cnt_q == LAST_CNT) state_d = BK_LIVE;
            end
            BK_HOLD: begin
                if (target == SUP_OFF)       state_d = BK_DARK;
                else if (target == SUP_FULL) state_d = BK_SETTLE;
            end
            BK_DARK: begin
                if (target == SUP_RET)       state_d = BK_HOLD;
                else if (target == SUP_FULL) state_d = BK_SETTLE;
            end
        endcase
    end

    assign enter_settle = (state_d == BK_SETTLE) && (state_q != BK_SETTLE);
    assign lost_set_o   = enter_settle && gone_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BK_LIVE;
            cnt_q   <= '0;
            gone_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == BK_SETTLE) ? cnt_q + 1'b1 : '0;
            if (state_d == BK_DARK) gone_q <= 1'b1;
            else if (enter_settle)  gone_q <= 1'b0;
        end
    end

    // outputs from state
    always_comb begin
        unique case (state_q)
            BK_DARK:   begin supply_o = SUP_OFF;  ready_o = 1'b0; end
            BK_HOLD:   begin supply_o = SUP_RET;  ready_o = 1'b0; end
            BK_SETTLE: begin supply_o = SUP_FULL; ready_o = 1'b0; end
            BK_LIVE:   begin supply_o = SUP_FULL; ready_o = 1'b1; end
        endcase
    end

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r2_off_bit_disconnects: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(off_i) |-> supply_o == SUP_OFF)
        else $error("R2 power-off bit did not disconnect");
    a_r3_chain_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(chain_on_i && !off_i) |-> supply_o == SUP_FULL)
        else $error("R3 chain on without full supply");
    a_r4_retention: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(!chain_on_i && !off_i && ret_en_i) |-> supply_o == SUP_RET)
        else $error("R4 retention supply missing");
    a_r5_disconnect: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(!chain_on_i && !off_i && !ret_en_i) |-> supply_o == SUP_OFF)
        else $error("R5 bank not disconnected");
    a_r6_ready_after_full: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $rose(ready_o) |-> $past(supply_o) == SUP_FULL)
        else $error("R6 ready rose without a settling period");
    a_r6_ready_drops_with_supply: assert property (@(posedge clk) disable iff (!rst_n)
        supply_o != SUP_FULL |-> !ready_o)
        else $error("R6 ready high without full supply");
endmodule

// File: rtl/srpc_cfg_regs.sv
module srpc_cfg_regs #(
    parameter int         NB        = 4,
    parameter logic [3:0] RSVD_INIT = 4'b0110,
    parameter int         AW        = $clog2(NB + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    wdata_i,
    output logic [7:0]    rdata_o,
    input  logic [NB-1:0] ready_i,
    input  logic [NB-1:0] lost_set_i,
    output logic [NB-1:0] off_o,
    output logic [NB-1:0] ret_en_o
);
    logic [NB-1:0] off_q, ret_q, lost_q;
    logic          unused_wbits;

    assign unused_wbits = ^{wdata_i[6], wdata_i[4]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      off_q <= '0;
        else if (wr_i && addr_i == '0)   off_q <= wdata_i[NB-1:0];
    end

    for (genvar n = 0; n < NB; n++) begin : g_ctl
        logic sel;
        assign sel = wr_i && (addr_i == AW'(n + 1));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ret_q[n]  <= 1'b1;
                lost_q[n] <= 1'b0;
            end else begin
                if (sel) ret_q[n] <= wdata_i[7];
                if (lost_set_i[n])            lost_q[n] <= 1'b1;
                else if (sel && wdata_i[5])   lost_q[n] <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == '0) rdata_o[NB-1:0] = off_q;
        for (int n = 0; n < NB; n++) begin
            if (addr_i == AW'(n + 1))
                rdata_o = {ret_q[n], ready_i[n], lost_q[n], 1'b0, RSVD_INIT};
        end
    end

    assign off_o    = off_q;
    assign ret_en_o = ret_q;

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    for (genvar n = 0; n < NB; n++) begin : g_chk
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && $past(lost_set_i[n]) |-> lost_q[n])
            else $error("R9 lost flag not set");
        a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && $fell(lost_q[n]) |-> $past(wr_i && addr_i == AW'(n + 1) && wdata_i[5]))
            else $error("R9 lost flag cleared without a write");
    end
endmodule

// File: rtl/srpc_bus_gate.sv
module srpc_bus_gate #(
    parameter int NB = 4,
    parameter int DW = 32,
    parameter int BW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [BW-1:0] bank_i,
    input  logic [DW-1:0] sram_rdata_i,
    input  logic [NB-1:0] ready_i,
    output logic [DW-1:0] rdata_o,
    output logic          err_o
);
    logic ok;
    assign ok = ready_i[bank_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_o   <= 1'b0;
            rdata_o <= '0;
        end else begin
            err_o   <= req_i && !ok;
            rdata_o <= (req_i && ok) ? sram_rdata_i : '0;
        end
    end

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r8_err_on_unready: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(req_i && !ready_i[bank_i]) |-> err_o && rdata_o == '0)
        else $error("R8 access to unready bank not flagged");
    a_r8_no_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(!req_i) |-> !err_o)
        else $error("R8 error without request");
endmodule

// File: rtl/sram_retention_ctrl.sv
module sram_retention_ctrl
    import srpc_pkg::*;
#(
    parameter int         NUM_BANKS  = 4,
    parameter int         SETTLE_CYC = 8,
    parameter int         DATA_W     = 32,
    parameter logic [3:0] RSVD_INIT  = 4'b0110
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             chain_on,
    input  logic                             cfg_wr,
    input  logic [$clog2(NUM_BANKS+1)-1:0]   cfg_addr,
    input  logic [7:0]                       cfg_wdata,
    output logic [7:0]                       cfg_rdata,
    input  logic                             bus_req,
    input  logic [$clog2(NUM_BANKS)-1:0]     bus_bank,
    input  logic [DATA_W-1:0]                sram_rdata,
    output logic [DATA_W-1:0]                bus_rdata,
    output logic                             bus_err,
    output logic [2*NUM_BANKS-1:0]           bank_supply,
    output logic [NUM_BANKS-1:0]             bank_access
);
    localparam int AW = $clog2(NUM_BANKS + 1);
    localparam int BW = $clog2(NUM_BANKS);

    logic [NUM_BANKS-1:0] off_w, ret_w, ready_w, lost_set_w;

    for (genvar n = 0; n < NUM_BANKS; n++) begin : g_bank
        supply_e sup;
        srpc_bank_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
            .clk        (clk),
            .rst_n      (rst_n),
            .chain_on_i (chain_on),
            .off_i      (off_w[n]),
            .ret_en_i   (ret_w[n]),
            .supply_o   (sup),
            .ready_o    (ready_w[n]),
            .lost_set_o (lost_set_w[n])
        );
        assign bank_supply[2*n +: 2] = sup;
    end

    srpc_cfg_regs #(.NB(NUM_BANKS), .RSVD_INIT(RSVD_INIT), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (cfg_wr),
        .addr_i     (cfg_addr),
        .wdata_i    (cfg_wdata),
        .rdata_o    (cfg_rdata),
        .ready_i    (ready_w),
        .lost_set_i (lost_set_w),
        .off_o      (off_w),
        .ret_en_o   (ret_w)
    );

    srpc_bus_gate #(.NB(NUM_BANKS), .DW(DATA_W), .BW(BW)) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (bus_req),
        .bank_i       (bus_bank),
        .sram_rdata_i (sram_rdata),
        .ready_i      (ready_w),
        .rdata_o      (bus_rdata),
        .err_o        (bus_err)
    );

    assign bank_access = ready_w;
endmodule

// File: tb/sim_sram_retention_ctrl.sv
module sim_sram_retention_ctrl;
    localparam int NB     = 4;
    localparam int SETTLE = 8;
    localparam logic [3:0] RSVD = 4'b0110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chain_on = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        bus_req = 1'b0;
    logic [1:0]  bus_bank = '0;
    logic [31:0] sram_rdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [7:0]  bank_supply;
    logic [3:0]  bank_access;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sram_retention_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .chain_on(chain_on),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_req(bus_req), .bus_bank(bus_bank), .sram_rdata(sram_rdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err),
        .bank_supply(bank_supply), .bank_access(bank_access)
    );

    // reference model: 0 dark, 1 hold, 2 settle, 3 live
    int m_st[NB], m_cnt[NB], nst[NB];
    bit m_gone[NB], m_off[NB], m_ret[NB], m_lost[NB], ls[NB];
    bit m_err;
    logic [31:0] m_rdata;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NB; n++) begin
                m_st[n] = 3; m_cnt[n] = 0; m_gone[n] = 0;
                m_off[n] = 0; m_ret[n] = 1; m_lost[n] = 0;
            end
            m_err = 0; m_rdata = '0;
        end else begin
            for (int n = 0; n < NB; n++) begin
                int t;
                if (m_off[n]) t = 0;
                else if (chain_on) t = 2;
                else if (m_ret[n]) t = 1;
                else t = 0;
                case (m_st[n])
                    3: nst[n] = (t == 0) ? 0 : (t == 1) ? 1 : 3;
                    2: nst[n] = (t == 0) ? 0 : (t == 1) ? 1 : (m_cnt[n] == SETTLE - 1) ? 3 : 2;
                    1: nst[n] = (t == 0) ? 0 : (t == 2) ? 2 : 1;
                    default: nst[n] = (t == 1) ? 1 : (t == 2) ? 2 : 0;
                endcase
                ls[n] = (nst[n] == 2) && (m_st[n] != 2) && m_gone[n];
            end
            m_err   = bus_req && (m_st[bus_bank] != 3);
            m_rdata = (bus_req && m_st[bus_bank] == 3) ? sram_rdata : '0;
            for (int n = 0; n < NB; n++) begin
                m_cnt[n] = (m_st[n] == 2) ? m_cnt[n] + 1 : 0;
                if (nst[n] == 0) m_gone[n] = 1;
                else if (nst[n] == 2 && m_st[n] != 2) m_gone[n] = 0;
                m_st[n] = nst[n];
            end
            if (cfg_wr && cfg_addr == 0)
                for (int n = 0; n < NB; n++) m_off[n] = cfg_wdata[n];
            for (int n = 0; n < NB; n++) begin
                if (cfg_wr && cfg_addr == 3'(n + 1)) begin
                    m_ret[n] = cfg_wdata[7];
                    if (cfg_wdata[5]) m_lost[n] = 0;
                end
                if (ls[n]) m_lost[n] = 1;
            end
        end
    end

    function automatic logic [7:0] exp_rd(logic [2:0] a);
        logic [7:0] r = '0;
        if (a == 0) for (int n = 0; n < NB; n++) r[n] = m_off[n];
        else if (a <= NB)
            r = {m_ret[a-1], (m_st[a-1] == 3) ? 1'b1 : 1'b0, m_lost[a-1], 1'b0, RSVD};
        return r;
    endfunction

    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic [7:0] es;
            logic [3:0] ea;
            for (int n = 0; n < NB; n++) begin
                es[2*n +: 2] = (m_st[n] == 0) ? 2'b00 : (m_st[n] == 1) ? 2'b01 : 2'b10;
                ea[n] = (m_st[n] == 3);
            end
            chk("R2 R3 R4 R5 supply", {24'd0, bank_supply}, {24'd0, es});
            chk("R6 access", {28'd0, bank_access}, {28'd0, ea});
            chk("R7 R9 R10 cfg_rdata", {24'd0, cfg_rdata}, {24'd0, exp_rd(cfg_addr)});
            chk("R8 bus_err", {31'd0, bus_err}, {31'd0, m_err});
            chk("R8 bus_rdata", bus_rdata, m_rdata);
        end
    end

    always @(negedge clk) sram_rdata <= $urandom;

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        cfg_wr = 0; bus_req = 0;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_addr = a; cfg_wdata = d; bus_req = 0;
        @(negedge clk);
        cfg_wr = 0; cfg_addr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 supply", {24'd0, bank_supply}, 32'h0000_00AA);
        chk("R1 access", {28'd0, bank_access}, 32'h0000_000F);
        chk("R1 off reg", {24'd0, cfg_rdata}, 32'h0);
        cfg_addr = 1; #0.5;
        chk("R1 R7 ctrl reg", {24'd0, cfg_rdata}, {24'd0, 1'b1, 1'b1, 2'b00, RSVD});
        // R7 reserved bits ignore writes, R10 map
        wr(1, 8'h5F);
        cfg_addr = 1; #0.5;
        chk("R7 reserved after write", {24'd0, cfg_rdata}, {24'd0, 4'b0100, RSVD});
        wr(1, 8'h80);
        // R8 ready bank access
        @(negedge clk); bus_req = 1; bus_bank = 0;
        idle(1);
        // R2 power off bank1, access it, then re-enable and hammer through settle (R6, R8, R9)
        wr(0, 8'h02);
        idle(3);
        @(negedge clk); bus_req = 1; bus_bank = 1;
        wr(0, 8'h00);
        bus_req = 1; bus_bank = 1;
        repeat (12) @(negedge clk);
        bus_req = 0;
        cfg_addr = 2; #0.5;
        chk("R9 lost set after off", {31'd0, cfg_rdata[5]}, 32'd1);
        wr(2, 8'hA0);
        // R4 R5 deep sleep: bank2 no retention, bank3 retention
        wr(3, 8'h00);
        @(negedge clk); chain_on = 0;
        idle(4);
        chk("R4 R5 sleep supply", {24'd0, bank_supply}, {24'd0, 2'b01, 2'b00, 2'b01, 2'b01});
        @(negedge clk); chain_on = 1; bus_req = 1; bus_bank = 2;
        repeat (12) @(negedge clk);
        bus_req = 0;
        // R9 set beats clear in the same cycle
        @(negedge clk); chain_on = 0;
        idle(4);
        @(negedge clk); chain_on = 1; cfg_wr = 1; cfg_addr = 3; cfg_wdata = 8'h20;
        @(negedge clk); cfg_wr = 0; cfg_addr = 3; #0.5;
        chk("R9 set wins over clear", {31'd0, cfg_rdata[5]}, 32'd1);
        idle(12);
        // random traffic against the model
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 15) == 0) chain_on = ~chain_on;
            cfg_wr    = ($urandom_range(0, 5) == 0);
            cfg_addr  = 3'($urandom_range(0, 6));
            cfg_wdata = 8'($urandom);
            bus_req   = $urandom_range(0, 1);
            bus_bank  = 2'($urandom_range(0, 3));
        end
        idle(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule